// File: doc/BRIEF.md
# PWM-Commanded Digital Current Regulator

This block closes a digital current loop for one inductive load channel. A slow command PWM (around 2 kHz) carries the wanted load current in its on-time. The block measures that on-time with a fast tick, turns it into a target current, and then drives a power-stage gate with its own fixed-period PWM. The duty of that output comes from a proportional-integral loop. The loop runs once per output period on a load-current word supplied from outside.

The output period is 64 reference-clock periods. The output timing is re-aligned to the first falling edge of the command after the block leaves idle, and runs free from then on. The first output period only measures current, so the gate stays off for that period. Until the measured current first reaches the target, the duty is pinned at its upper limit. The block drops back to idle when the command period is too long or the enable is removed. It halts for the rest of the command cycle when the recirculation path is reported broken. A duty that stays at either limit for too long raises a regulation-error flag.

Current values are in 5 mA units, so a target code of 50 means 250 mA and 450 means 2.25 A. The duty register counts in 1/128 steps of the output period.

Top module: `pwm_current_regulator`

## Requirements
- R1: After reset the gate is low, the duty register reads 115 (the upper limit) and the regulation-error flag is low.
- R2: The command on-time is counted in `meas_tick` pulses from its rising edge to its falling edge, and is then clamped to the range 50..450. The clamped count is the target in 5 mA units, and it is latched at the command's falling edge.
- R3: When a newly latched target differs from the previous one, the duty is pinned at 115 again until the sampled current reaches the new target.
- R4: In idle, with enable high, the first command falling edge starts an output frame. The gate stays low for that whole frame of 64 `ref_tick` periods, and it turns on at the start of the next frame.
- R5: Each output frame lasts 64 `ref_tick` periods. The gate is high while twice the frame position is below the duty, so it is high for the first ceil(duty/2) reference periods of the frame.
- R6: While pinned, every frame end writes duty 115. The first frame end that samples a current at or above the target releases the pin and keeps duty 115 for that frame. At that point the integrator is preset to 115·256.
- R7: When not pinned, each frame end takes e = target − current. It computes I' = clamp(I + 32·e, 13·256, 115·256) and duty = clamp((I' + 246·e) >>> 8, 13, 115). A raw value above 115 pins the duty again. The duty never leaves 13..115.
- R8: After `ERR_FRAMES` consecutive frame-end samples with duty at 13 or 115, `reg_err` rises. It falls at the first sample that lands strictly inside the range.
- R9: `recirc_ok` low forces the gate low in the same cycle. The loop then halts until the next command rising edge, after which a falling edge and a full measuring frame are needed before the gate turns on again.
- R10: When more than 132 `ref_tick` periods pass without a command rising edge, the block returns to idle. The gate then stays low, the duty reads 115 and `reg_err` is low.
- R11: `en` low sends the block to idle at the next edge. The gate is then low, and the loop state is cleared as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period (frame and period timing) |
| meas_tick | input | 1 | Fast measurement tick for the command on-time |
| en | input | 1 | Channel enable |
| cmd | input | 1 | Command PWM, synchronous to clk |
| cur_code | input | CUR_W | Sampled load current, 5 mA units |
| recirc_ok | input | 1 | High while the recirculation path is intact |
| gate | output | 1 | Power-stage gate drive |
| duty | output | 7 | Output duty register, 1/128 of the frame |
| reg_err | output | 1 | Duty held at a limit for too long |

## Verification
The bench builds the block with `ERR_FRAMES` set to 5 instead of 40, so the regulation-error flag can be raised and cleared at both duty limits within a few frames. The other parameters stay at their defaults: 64-tick frames, the 132-tick period limit and the 50..450 clamp. As a result, frame lengths, the gate-high counts of 232 and 28 cycles, the exact PI duty sequence 115, 104, 102 and the period timeout are all checked at their real sizes. The reference tick comes every fourth clock and the measurement tick every clock, so on-time counts equal the number of clock cycles the command is high.

// File: rtl/creg_pkg.sv
package creg_pkg;

    localparam int DUTY_W      = 7;
    localparam int FRAME_W     = DUTY_W - 1;
    localparam int FRAME_TICKS = 1 << FRAME_W;
    localparam int FRAC        = 8;
    localparam int ACC_W       = 20;

    typedef logic [DUTY_W-1:0] duty_t;

    localparam duty_t DUTY_MIN = duty_t'(13);
    localparam duty_t DUTY_MAX = duty_t'(115);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_RUN,
        ST_HALT
    } reg_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic bad;
    } cmd_evt_t;

    typedef logic signed [ACC_W-1:0] acc_t;

    function automatic acc_t clip(input acc_t v, input acc_t lo, input acc_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/creg_cmd_meter.sv
module creg_cmd_meter
    import creg_pkg::*;
#(
    parameter int CUR_W         = 9,
    parameter int ON_W          = 10,
    parameter int ON_MIN        = 50,
    parameter int ON_MAX        = 450,
    parameter int MAX_CMD_TICKS = 132
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             meas_tick,
    input  logic             cmd,
    output cmd_evt_t         evt,
    output logic [CUR_W-1:0] target,
    output logic             tgt_chg
);

    localparam int PER_W = $clog2(MAX_CMD_TICKS + 2);

    logic             cmd_q, cmd_d, seen_rise;
    logic [ON_W-1:0]  on_cnt;
    logic [PER_W-1:0] per_cnt;
    logic [CUR_W-1:0] tgt_new;

    always_comb begin
        evt.rise = cmd_q & ~cmd_d;
        evt.fall = ~cmd_q & cmd_d & seen_rise;
        evt.bad  = per_cnt > PER_W'(MAX_CMD_TICKS);
        if (on_cnt < ON_W'(ON_MIN))
            tgt_new = CUR_W'(ON_MIN);
        else if (on_cnt > ON_W'(ON_MAX))
            tgt_new = CUR_W'(ON_MAX);
        else
            tgt_new = CUR_W'(on_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= 1'b0;
            cmd_d     <= 1'b0;
            seen_rise <= 1'b0;
            on_cnt    <= '0;
            per_cnt   <= '0;
            target    <= '0;
            tgt_chg   <= 1'b0;
        end else begin
            cmd_q   <= cmd;
            cmd_d   <= cmd_q;
            tgt_chg <= 1'b0;
            if (evt.rise) begin
                seen_rise <= 1'b1;
                on_cnt    <= ON_W'(meas_tick);
                per_cnt   <= '0;
            end else begin
                if (cmd_q && meas_tick && on_cnt != '1)
                    on_cnt <= on_cnt + 1'b1;
                if (ref_tick && per_cnt <= PER_W'(MAX_CMD_TICKS))
                    per_cnt <= per_cnt + 1'b1;
            end
            if (evt.fall) begin
                target  <= tgt_new;
                tgt_chg <= (tgt_new != target);
            end
        end
    end

endmodule

// File: rtl/creg_frame.sv
module creg_frame
    import creg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_tick,
    input  logic               run,
    input  logic               restart,
    output logic [FRAME_W-1:0] pos,
    output logic               wrap
);

    assign wrap = run && ref_tick && (pos == '1);

    always_ff @(posedge clk) begin
        if (rst || restart)
            pos <= '0;
        else if (run && ref_tick)
            pos <= pos + 1'b1;
    end

endmodule

// File: rtl/creg_pi.sv
module creg_pi
    import creg_pkg::*;
#(
    parameter int CUR_W      = 9,
    parameter int KP         = 246,
    parameter int KI         = 32,
    parameter int ERR_FRAMES = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  logic             tgt_chg,
    input  logic [CUR_W-1:0] target,
    input  logic [CUR_W-1:0] cur,
    output duty_t            duty,
    output logic             reg_err
);

    localparam int   CNT_W = $clog2(ERR_FRAMES + 1);
    localparam acc_t KP_S  = acc_t'(KP);
    localparam acc_t KI_S  = acc_t'(KI);
    localparam acc_t D_LO  = acc_t'(int'(DUTY_MIN));
    localparam acc_t D_HI  = acc_t'(int'(DUTY_MAX));
    localparam acc_t Q_LO  = acc_t'(int'(DUTY_MIN) * (1 << FRAC));
    localparam acc_t Q_HI  = acc_t'(int'(DUTY_MAX) * (1 << FRAC));

    logic             lock;
    acc_t             integ, err, integ_n, sum_p, raw;
    duty_t            duty_n, d_next;
    logic             at_lim;
    logic [CNT_W-1:0] sat_cnt;

    always_comb begin
        err     = $signed({{(ACC_W-CUR_W){1'b0}}, target})
                - $signed({{(ACC_W-CUR_W){1'b0}}, cur});
        integ_n = clip(integ + KI_S * err, Q_LO, Q_HI);
        sum_p   = integ_n + KP_S * err;
        raw     = sum_p >>> FRAC;
        duty_n  = duty_t'(clip(raw, D_LO, D_HI));
        d_next  = lock ? DUTY_MAX : duty_n;
        at_lim  = (d_next == DUTY_MIN) || (d_next == DUTY_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lock    <= 1'b1;
            integ   <= Q_HI;
            duty    <= DUTY_MAX;
            sat_cnt <= '0;
            reg_err <= 1'b0;
        end else begin
            if (sample) begin
                duty <= d_next;
                if (lock) begin
                    if (cur >= target) begin
                        lock  <= 1'b0;
                        integ <= Q_HI;
                    end
                end else begin
                    integ <= integ_n;
                    if (raw > D_HI)
                        lock <= 1'b1;
                end
                if (at_lim) begin
                    if (sat_cnt != CNT_W'(ERR_FRAMES))
                        sat_cnt <= sat_cnt + 1'b1;
                    if (sat_cnt >= CNT_W'(ERR_FRAMES - 1))
                        reg_err <= 1'b1;
                end else begin
                    sat_cnt <= '0;
                    reg_err <= 1'b0;
                end
            end
            if (tgt_chg)
                lock <= 1'b1;
        end
    end

endmodule

// File: rtl/pwm_current_regulator.sv
module pwm_current_regulator
    import creg_pkg::*;
#(
    parameter int CUR_W         = 9,
    parameter int ON_W          = 10,
    parameter int ON_MIN        = 50,
    parameter int ON_MAX        = 450,
    parameter int MAX_CMD_TICKS = 132,
    parameter int ERR_FRAMES    = 40,
    parameter int KP            = 246,
    parameter int KI            = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             meas_tick,
    input  logic             en,
    input  logic             cmd,
    input  logic [CUR_W-1:0] cur_code,
    input  logic             recirc_ok,
    output logic             gate,
    output duty_t            duty,
    output logic             reg_err
);

    reg_state_e         st_q, st_d;
    cmd_evt_t           evt;
    logic               cmd_bad;
    logic [CUR_W-1:0]   target;
    logic               tgt_chg;
    logic [FRAME_W-1:0] pos;
    logic               wrap, go, running, clear;

    assign cmd_bad = evt.bad;
    assign go      = (st_q == ST_IDLE) && en && evt.fall && !evt.bad;
    assign running = (st_q == ST_MEASURE) || (st_q == ST_RUN);
    assign clear   = (st_q == ST_IDLE) || (st_q == ST_HALT);
    assign gate    = (st_q == ST_RUN) && recirc_ok && ({pos, 1'b0} < duty);

    creg_cmd_meter #(
        .CUR_W(CUR_W), .ON_W(ON_W), .ON_MIN(ON_MIN), .ON_MAX(ON_MAX),
        .MAX_CMD_TICKS(MAX_CMD_TICKS)
    ) u_meter (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .meas_tick(meas_tick),
        .cmd(cmd), .evt(evt), .target(target), .tgt_chg(tgt_chg)
    );

    creg_frame u_frame (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .run(running),
        .restart(go), .pos(pos), .wrap(wrap)
    );

    creg_pi #(
        .CUR_W(CUR_W), .KP(KP), .KI(KI), .ERR_FRAMES(ERR_FRAMES)
    ) u_pi (
        .clk(clk), .rst(rst), .clear(clear), .sample(wrap), .tgt_chg(tgt_chg),
        .target(target), .cur(cur_code), .duty(duty), .reg_err(reg_err)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (go) st_d = ST_MEASURE;
            ST_MEASURE, ST_RUN: begin
                if (!en || evt.bad)
                    st_d = ST_IDLE;
                else if (!recirc_ok)
                    st_d = ST_HALT;
                else if (st_q == ST_MEASURE && wrap)
                    st_d = ST_RUN;
            end
            ST_HALT: if (!en || evt.bad || evt.rise) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/pwm_current_regulator_chk.sv
module pwm_current_regulator_chk
    import creg_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  en,
    input logic  recirc_ok,
    input logic  gate,
    input logic  bad,
    input logic  reg_err,
    input duty_t duty
);

    AST_EN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !gate) else $error("gate on after enable removed"); // R11

    AST_RECIRC_CUT: assert property (@(posedge clk) disable iff (rst)
        !recirc_ok |-> !gate) else $error("gate on with open recirculation"); // R9

    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst)
        (duty >= DUTY_MIN) && (duty <= DUTY_MAX)) else $error("duty out of range"); // R7

    AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        reg_err |-> (duty == DUTY_MIN || duty == DUTY_MAX)) else $error("error flag off limit"); // R8

    AST_BAD_PERIOD_OFF: assert property (@(posedge clk) disable iff (rst)
        bad |=> !gate) else $error("gate on after bad command period"); // R10

endmodule

bind pwm_current_regulator pwm_current_regulator_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .recirc_ok(recirc_ok), .gate(gate),
    .bad(cmd_bad), .reg_err(reg_err), .duty(duty)
);

// File: tb/sim_pwm_current_regulator.sv
module sim_pwm_current_regulator;
    import creg_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       meas_tick = 1'b1;
    logic       en = 1'b0;
    logic       cmd = 1'b0;
    logic       recirc_ok = 1'b1;
    logic [8:0] cur_code = '0;
    logic       gate, reg_err, ref_tick;
    duty_t      duty;
    int         tick_div = 0;

    always #5 clk = ~clk;
    always @(posedge clk) tick_div <= (tick_div + 1) % 4;
    assign ref_tick = (tick_div == 3);

    pwm_current_regulator #(.ERR_FRAMES(5)) u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .meas_tick(meas_tick),
        .en(en), .cmd(cmd), .cur_code(cur_code), .recirc_ok(recirc_ok),
        .gate(gate), .duty(duty), .reg_err(reg_err)
    );

    // scoreboard
    string q_req[$];
    int    q_sel[$];
    int    q_exp[$];
    event  chk_ev;
    int    n_cmp = 0, n_bad = 0, meas = 0;
    bit    done = 0;

    function automatic int probe(int sel);
        case (sel)
            0: return int'(gate);
            1: return int'(duty);
            2: return int'(reg_err);
            default: return meas;
        endcase
    endfunction

    task automatic expect_item(string req, int sel, int exp);
        q_req.push_back(req);
        q_sel.push_back(sel);
        q_exp.push_back(exp);
        ->chk_ev;
        #1;
    endtask

    initial forever begin
        @(chk_ev);
        while (q_req.size() > 0) begin
            string r;
            int s, e, a;
            r = q_req.pop_front();
            s = q_sel.pop_front();
            e = q_exp.pop_front();
            a = probe(s);
            n_cmp++;
            if (a != e) begin
                n_bad++;
                $display("FAIL %s: actual %0d expected %0d", r, a, e);
            end
        end
    end

    // command generator: fixed 500-cycle period, cmd_hi cycles high
    bit gen_on = 0;
    int cmd_hi = 200;
    initial forever begin
        if (gen_on) begin
            int h;
            h = cmd_hi;
            cmd = 1'b1;
            repeat (h) @(negedge clk);
            cmd = 1'b0;
            repeat (500 - h) @(negedge clk);
        end else begin
            @(negedge clk);
        end
    end

    task automatic wait_rise();
        @(posedge gate);
        @(negedge clk);
    endtask

    task automatic frame_high(output int c);
        @(posedge gate);
        c = 0;
        repeat (256) begin
            @(negedge clk);
            if (gate) c++;
        end
    endtask

    task automatic high_over(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (gate) c++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_item("R1 gate", 0, 0);
        expect_item("R1 duty", 1, 115);
        expect_item("R1 reg_err", 2, 0);

        // R4: measuring frame before first turn-on
        en = 1'b1;
        gen_on = 1;
        @(negedge cmd);
        c = 0;
        while (!gate && c < 400) begin
            @(negedge clk);
            c++;
        end
        meas = (c >= 250 && c <= 265) ? 1 : 0;
        expect_item("R4 first turn-on delay", 3, 1);
        expect_item("R6 pinned duty", 1, 115);
        expect_item("R8 no error yet", 2, 0);

        // R5: gate width at duty 115
        frame_high(c);
        meas = c;
        expect_item("R5 high cycles at 115", 3, 232);

        // R8: pinned too long
        repeat (4) wait_rise();
        expect_item("R8 error at upper limit", 2, 1);

        // R6/R7: release and PI steps with e = -10
        wait_rise();
        cur_code = 9'd210;
        wait_rise();
        expect_item("R6 release keeps 115", 1, 115);
        wait_rise();
        expect_item("R7 first PI duty", 1, 104);
        expect_item("R8 error clears inside range", 2, 0);
        wait_rise();
        expect_item("R7 second PI duty", 1, 102);

        // R7/R5/R8: lower limit
        cur_code = 9'd511;
        wait_rise();
        expect_item("R7 lower clamp", 1, 13);
        frame_high(c);
        meas = c;
        expect_item("R5 high cycles at 13", 3, 28);
        repeat (5) wait_rise();
        expect_item("R8 error at lower limit", 2, 1);

        // R3: target change pins duty again
        cur_code = 9'd210;
        cmd_hi = 300;
        repeat (1500) @(negedge clk);
        expect_item("R3 relock on new target", 1, 115);

        // R2: low clamp (target 50, current 40 keeps pin)
        cmd_hi = 20;
        cur_code = 9'd40;
        repeat (1500) @(negedge clk);
        expect_item("R2 low clamp", 1, 115);

        // R2: high clamp (target 450, current 460 releases)
        cmd_hi = 480;
        cur_code = 9'd460;
        repeat (2000) @(negedge clk);
        meas = (duty < 7'd115) ? 1 : 0;
        expect_item("R2 high clamp", 3, 1);

        // R9: recirculation fault
        wait_rise();
        recirc_ok = 1'b0;
        #1;
        expect_item("R9 gate cut at once", 0, 0);
        repeat (10) @(negedge clk);
        recirc_ok = 1'b1;
        repeat (150) @(negedge clk);
        expect_item("R9 halted after restore", 0, 0);
        frame_high(c);
        meas = (c > 0) ? 1 : 0;
        expect_item("R9 resumes later", 3, 1);

        // R10: command stops
        gen_on = 0;
        repeat (1300) @(negedge clk);
        high_over(400, c);
        meas = c;
        expect_item("R10 gate stays off", 3, 0);
        expect_item("R10 duty cleared", 1, 115);
        expect_item("R10 error cleared", 2, 0);

        // R11: enable removed
        cur_code = 9'd0;
        cmd_hi = 200;
        gen_on = 1;
        wait_rise();
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_item("R11 gate off", 0, 0);
        expect_item("R11 duty cleared", 1, 115);
        high_over(300, c);
        meas = c;
        expect_item("R11 gate stays off", 3, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule